// File: doc/BRIEF.md
# Debug Halt and Scan Control Port

This block sits between a test access port and a processor core and gives an external debugger control over halting the core. The TAP state machine lives elsewhere. It hands the block one-cycle strobes for the capture, shift and update states of the instruction and data paths. The block shifts serial data in on `tdi` and out on `tdo`, least significant bit first. It keeps an 8-bit instruction register that selects which data register the data path reaches: a small halt/control register, a read-only core-state scan register, or a debug-control register that holds the external-debug-mode bit.

On the instruction path the block does not shift out the previous instruction. It shifts out a status word that reports whether the core clock is running and whether the core has entered its debug state. A debugger halts the core by writing the control register with both its request and wake bits set. It confirms the halt by scanning the instruction path. It can then read the core state word without disturbing the halt. The first write to the debug-control register changes only the mode bit. Later writes load every field and never clear that bit again.

Top module: `dbg_scan_port`

## Requirements
- R1: While `dbg_enable` is low, every capture, shift and update strobe is ignored: no register changes and `tdo` stays 0.
- R2: The instruction register is 8 bits wide and loads only on an instruction-path update. Code 0x12 selects the 4-bit control register, 0x10 selects the 32-bit core-state register and 0x30 selects the 32-bit debug-control register. Every other code selects a 1-bit bypass that captures 0. The instruction register resets to 0xFF.
- R3: An instruction-path capture loads the status word. Bit 0 is `cpu_clk_running`, bit 1 is the debug-state flag, and all other bits are 0. The word is shifted out during the instruction-path shift cycles.
- R4: The control register fields are: bit 0 debug request, bit 1 wake, bit 2 instruction translation-miss disable, bit 3 data translation-miss disable. `halt_req` is high exactly when bits 0 and 1 are both set. `wake_req`, `imiss_dis` and `dmiss_dis` follow bits 1, 2 and 3 as levels.
- R5: The debug-state flag is set by `cpu_halt_ack` while `halt_req` is high. It is cleared by `cpu_halt_ack` while `halt_req` is low. Otherwise it holds.
- R6: With the core-state register selected, a data capture loads `cpu_state_word`, and a data update changes no register and no output.
- R7: The first debug-control write after reset changes only bit 31. Every other bit keeps its old value.
- R8: Later debug-control writes load all 32 bits. Once bit 31 is set, it stays set until reset.
- R9: `dbg_mode_en` equals bit 31 of the debug-control register.
- R10: Shifting never changes a stored register. Only an update strobe does, and a capture of the control or debug-control register reads back its stored value.
- R11: Reset clears the control register, the debug-control register and the debug-state flag, and re-arms the first-write rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_enable | input | 1 | Port enable; all strobes ignored when low |
| tap_capture_ir | input | 1 | Instruction-path capture strobe |
| tap_shift_ir | input | 1 | Instruction-path shift strobe |
| tap_update_ir | input | 1 | Instruction-path update strobe |
| tap_capture_dr | input | 1 | Data-path capture strobe |
| tap_shift_dr | input | 1 | Data-path shift strobe |
| tap_update_dr | input | 1 | Data-path update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cpu_halt_ack | input | 1 | Core acknowledge of a halt or release |
| cpu_clk_running | input | 1 | Core clock running indication |
| cpu_state_word | input | 32 | Core state presented for scan |
| halt_req | output | 1 | Request the core to halt into its debug state |
| wake_req | output | 1 | Wake level to the core |
| dbg_mode_en | output | 1 | External debug mode enable |
| imiss_dis | output | 1 | Instruction translation-miss disable |
| dmiss_dis | output | 1 | Data translation-miss disable |

## Verification
The assertions check on every cycle the following rules: a disabled port leaves its registers unchanged and holds `tdo` low; only update strobes alter stored values; a write with both request bits set raises the halt; the first debug-control write touches only the mode bit, and that bit never falls; the debug-state flag moves only on an acknowledge. The bench scenarios show the behaviour that depends on the serial path: the status word read on the instruction path, core-state readback during a halt, bypass capture, and the exact values read back after first and later debug-control writes. They also show that a scan without an update, or a scan while disabled, leaves the stored contents as they were.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;
    localparam int IR_W    = 8;
    localparam int CTL_W   = 4;
    localparam int DR_MAX  = 32;
    localparam int EDM_BIT = 31;
    localparam int STAT_W  = 2;
    localparam int LEN_W   = $clog2(DR_MAX + 1);

    localparam logic [IR_W-1:0] SEL_CORE   = 8'h10;
    localparam logic [IR_W-1:0] SEL_CTL    = 8'h12;
    localparam logic [IR_W-1:0] SEL_DBC0   = 8'h30;
    localparam logic [IR_W-1:0] SEL_BYPASS = 8'hFF;

    typedef struct packed {
        logic dmiss_dis;
        logic imiss_dis;
        logic wake;
        logic dbg_req;
    } ctl_t;

    typedef enum logic [1:0] {
        PATH_IDLE,
        PATH_IR,
        PATH_DR
    } path_e;

    function automatic logic [LEN_W-1:0] dr_len(input logic [IR_W-1:0] code);
        case (code)
            SEL_CTL:  return LEN_W'(CTL_W);
            SEL_CORE: return LEN_W'(DR_MAX);
            SEL_DBC0: return LEN_W'(DR_MAX);
            default:  return LEN_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/jdbg_ir_path.sv
module jdbg_ir_path
    import jdbg_pkg::*;
#(
    parameter int W  = IR_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cap,
    input  logic          shf,
    input  logic          upd,
    input  logic          tdi,
    input  logic [SW-1:0] status,
    output logic [W-1:0]  ir_q,
    output logic          tdo_bit
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            ir_q <= W'(SEL_BYPASS);
        end else if (en) begin
            if (cap)
                sr_q <= W'(status);
            else if (shf)
                sr_q <= {tdi, sr_q[W-1:1]};
            if (upd)
                ir_q <= sr_q;
        end
    end

    assign tdo_bit = sr_q[0];

    AST_IR_UPDATE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(en && upd) |=> $stable(ir_q)); // R2
endmodule

// File: rtl/jdbg_dr_path.sv
module jdbg_dr_path
    import jdbg_pkg::*;
#(
    parameter int W  = DR_MAX,
    parameter int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cap,
    input  logic          shf,
    input  logic [LW-1:0] len,
    input  logic [W-1:0]  cap_val,
    input  logic          tdi,
    output logic [W-1:0]  sr_q,
    output logic          tdo_bit
);
    localparam int IDX_W = $clog2(W);

    logic [IDX_W-1:0] last_idx;
    logic [W-1:0]     nxt;

    assign last_idx = IDX_W'(len - 1'b1);

    always_comb begin
        nxt           = {1'b0, sr_q[W-1:1]};
        nxt[last_idx] = tdi;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (en && cap)
            sr_q <= cap_val;
        else if (en && shf)
            sr_q <= nxt;
    end

    assign tdo_bit = sr_q[0];
endmodule

// File: rtl/jdbg_regs.sv
module jdbg_regs
    import jdbg_pkg::*;
#(
    parameter int W   = DR_MAX,
    parameter int EDM = EDM_BIT,
    parameter int IW  = IR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          upd,
    input  logic [IW-1:0] ir,
    input  logic [W-1:0]  data,
    input  logic          halt_ack,
    output ctl_t          ctl_q,
    output logic [W-1:0]  dbc0_q,
    output logic          dbg_state_q,
    output logic          halt_q
);
    localparam logic [W-1:0] EDM_MASK = W'(1) << EDM;

    logic wr_ctl, wr_dbc, first_q;

    assign wr_ctl = en && upd && (ir == IW'(SEL_CTL));
    assign wr_dbc = en && upd && (ir == IW'(SEL_DBC0));
    assign halt_q = ctl_q.dbg_req & ctl_q.wake;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr_ctl)
            ctl_q <= ctl_t'(data[CTL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbc0_q  <= '0;
            first_q <= 1'b1;
        end else if (wr_dbc) begin
            first_q <= 1'b0;
            if (first_q)
                dbc0_q[EDM] <= data[EDM];
            else
                dbc0_q <= data | (dbc0_q & EDM_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dbg_state_q <= 1'b0;
        else if (halt_ack)
            dbg_state_q <= halt_q;
    end

    AST_HALT_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        wr_ctl && data[0] && data[1] |=> halt_q); // R4
    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(ctl_q) && $stable(dbc0_q)); // R1
    AST_UPDATE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(ctl_q) && $stable(dbc0_q)); // R10
    AST_FIRST_EDM_ONLY: assert property (@(posedge clk) disable iff (rst)
        wr_dbc && first_q |=> (dbc0_q & ~EDM_MASK) == ($past(dbc0_q) & ~EDM_MASK)); // R7
    AST_EDM_STICKY: assert property (@(posedge clk) disable iff (rst)
        dbc0_q[EDM] |=> dbc0_q[EDM]); // R8
    AST_DBGST_SET: assert property (@(posedge clk) disable iff (rst)
        halt_ack && halt_q |=> dbg_state_q); // R5
    AST_DBGST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !halt_ack |=> $stable(dbg_state_q)); // R5
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
    import jdbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_enable,
    input  logic              tap_capture_ir,
    input  logic              tap_shift_ir,
    input  logic              tap_update_ir,
    input  logic              tap_capture_dr,
    input  logic              tap_shift_dr,
    input  logic              tap_update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              cpu_halt_ack,
    input  logic              cpu_clk_running,
    input  logic [DR_MAX-1:0] cpu_state_word,
    output logic              halt_req,
    output logic              wake_req,
    output logic              dbg_mode_en,
    output logic              imiss_dis,
    output logic              dmiss_dis
);
    logic [IR_W-1:0]   ir_q;
    logic [DR_MAX-1:0] dr_sr, dbc0_q, cap_val;
    logic [LEN_W-1:0]  len;
    logic              tdo_ir, tdo_dr, dbg_state_q;
    ctl_t              ctl_q;
    path_e             path;

    assign len = dr_len(ir_q);

    always_comb begin
        case (ir_q)
            SEL_CTL:  cap_val = DR_MAX'(ctl_q);
            SEL_DBC0: cap_val = dbc0_q;
            SEL_CORE: cap_val = cpu_state_word;
            default:  cap_val = '0;
        endcase
    end

    jdbg_ir_path #(.W(IR_W), .SW(STAT_W)) u_ir (
        .clk     (clk),
        .rst     (rst),
        .en      (dbg_enable),
        .cap     (tap_capture_ir),
        .shf     (tap_shift_ir),
        .upd     (tap_update_ir),
        .tdi     (tdi),
        .status  ({dbg_state_q, cpu_clk_running}),
        .ir_q    (ir_q),
        .tdo_bit (tdo_ir)
    );

    jdbg_dr_path #(.W(DR_MAX), .LW(LEN_W)) u_dr (
        .clk     (clk),
        .rst     (rst),
        .en      (dbg_enable),
        .cap     (tap_capture_dr),
        .shf     (tap_shift_dr),
        .len     (len),
        .cap_val (cap_val),
        .tdi     (tdi),
        .sr_q    (dr_sr),
        .tdo_bit (tdo_dr)
    );

    jdbg_regs #(.W(DR_MAX), .EDM(EDM_BIT), .IW(IR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .en          (dbg_enable),
        .upd         (tap_update_dr),
        .ir          (ir_q),
        .data        (dr_sr),
        .halt_ack    (cpu_halt_ack),
        .ctl_q       (ctl_q),
        .dbc0_q      (dbc0_q),
        .dbg_state_q (dbg_state_q),
        .halt_q      (halt_req)
    );

    always_comb begin
        if (!dbg_enable)       path = PATH_IDLE;
        else if (tap_shift_ir) path = PATH_IR;
        else if (tap_shift_dr) path = PATH_DR;
        else                   path = PATH_IDLE;
    end

    always_comb begin
        case (path)
            PATH_IR: tdo = tdo_ir;
            PATH_DR: tdo = tdo_dr;
            default: tdo = 1'b0;
        endcase
    end

    assign wake_req    = ctl_q.wake;
    assign imiss_dis   = ctl_q.imiss_dis;
    assign dmiss_dis   = ctl_q.dmiss_dis;
    assign dbg_mode_en = dbc0_q[EDM_BIT];

    AST_TDO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dbg_enable |-> !tdo); // R1
endmodule

// File: tb/dbg_scan_port_bench.sv
module dbg_scan_port_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic cir = 1'b0, sir = 1'b0, uir = 1'b0;
    logic cdr = 1'b0, sdr = 1'b0, udr = 1'b0;
    logic tdi = 1'b0, ack = 1'b0, clk_run = 1'b1;
    logic [31:0] state_word = '0;
    logic tdo, halt_req, wake_req, dm_en, imiss, dmiss;

    int n_cmp = 0, n_bad = 0;
    bit live = 1'b0, done = 1'b0;

    // behavioural model
    logic [3:0]  m_ctl = '0;
    logic [31:0] m_dbc = '0;
    bit          m_first = 1'b1;
    bit          m_dbgst = 1'b0;
    logic [7:0]  m_ir = 8'hFF;

    always #5 clk = ~clk;

    dbg_scan_port u_dbg_scan_port (
        .clk(clk), .rst(rst), .dbg_enable(en),
        .tap_capture_ir(cir), .tap_shift_ir(sir), .tap_update_ir(uir),
        .tap_capture_dr(cdr), .tap_shift_dr(sdr), .tap_update_dr(udr),
        .tdi(tdi), .tdo(tdo), .cpu_halt_ack(ack), .cpu_clk_running(clk_run),
        .cpu_state_word(state_word), .halt_req(halt_req), .wake_req(wake_req),
        .dbg_mode_en(dm_en), .imiss_dis(imiss), .dmiss_dis(dmiss)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison of the level outputs against the model
    always @(negedge clk) begin
        if (live) begin
            #2;
            chk("R4 halt_req", 32'(halt_req), 32'(m_ctl[0] & m_ctl[1]));
            chk("R4 wake/miss", {29'd0, dmiss, imiss, wake_req}, {29'd0, m_ctl[3:1]});
            chk("R9 dbg_mode_en", 32'(dm_en), 32'(m_dbc[31]));
        end
    end

    task automatic scan_ir(input logic [7:0] code, output logic [7:0] dout);
        @(negedge clk); cir = 1'b1;
        @(negedge clk); cir = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sir = 1'b1; tdi = code[i];
            #1 dout[i] = tdo;
            @(negedge clk);
        end
        sir = 1'b0; uir = 1'b1;
        @(negedge clk); uir = 1'b0;
        if (en) m_ir = code;
    endtask

    task automatic scan_dr(input int len, input logic [31:0] din, input bit upd,
                           output logic [31:0] dout);
        dout = '0;
        @(negedge clk); cdr = 1'b1;
        @(negedge clk); cdr = 1'b0;
        for (int i = 0; i < len; i++) begin
            sdr = 1'b1; tdi = din[i];
            #1 dout[i] = tdo;
            @(negedge clk);
        end
        sdr = 1'b0; udr = upd;
        @(negedge clk); udr = 1'b0;
        if (en && upd) begin
            if (m_ir == 8'h12) m_ctl = din[3:0];
            else if (m_ir == 8'h30) begin
                if (m_first) m_dbc[31] = din[31];
                else m_dbc = din | {m_dbc[31], 31'd0};
                m_first = 1'b0;
            end
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        m_dbgst = m_ctl[0] & m_ctl[1];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  ir_out;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        chk("R11 reset outputs", {27'd0, halt_req, wake_req, dm_en, imiss, dmiss}, 32'd0);
        live = 1'b1;

        // status word and bypass after reset
        scan_ir(8'hFF, ir_out);
        chk("R3 status after reset", 32'(ir_out), 32'h1);
        scan_dr(1, 32'h1, 1'b1, d);
        chk("R2 bypass captures 0", d, 32'h0);

        // halt request
        scan_ir(8'h12, ir_out);
        scan_dr(4, 32'h3, 1'b1, d);
        chk("R11 control reset value", d, 32'h0);
        pulse_ack();
        scan_ir(8'h12, ir_out);
        chk("R5 debug state set", 32'(ir_out), 32'h3);
        clk_run = 1'b0;
        scan_ir(8'h10, ir_out);
        chk("R3 clock stopped status", 32'(ir_out), 32'h2);
        clk_run = 1'b1;

        // core state read while halted
        state_word = 32'hCAFE_0123;
        scan_dr(32, 32'h5555_AAAA, 1'b1, d);
        chk("R6 core state capture", d, 32'hCAFE_0123);
        scan_ir(8'h12, ir_out);
        scan_dr(4, 32'h3, 1'b0, d);
        chk("R6 halt kept after core scan", d, 32'h3);

        // debug-control first and later writes
        scan_ir(8'h30, ir_out);
        scan_dr(32, 32'h8000_00AB, 1'b1, d);
        chk("R11 debug-control reset value", d, 32'h0);
        scan_dr(32, 32'h0000_1234, 1'b1, d);
        chk("R7 first write only mode bit", d, 32'h8000_0000);
        scan_dr(32, 32'h0, 1'b1, d);
        chk("R8 later write all fields", d, 32'h8000_1234);
        scan_dr(32, 32'h0, 1'b0, d);
        chk("R8 mode bit stays set", d, 32'h8000_0000);

        // shift without update
        scan_ir(8'h12, ir_out);
        scan_dr(4, 32'hC, 1'b0, d);
        chk("R10 readback", d, 32'h3);
        scan_dr(4, 32'hF, 1'b0, d);
        chk("R10 shift leaves value", d, 32'h3);

        // disabled port
        en = 1'b0;
        scan_ir(8'h30, ir_out);
        chk("R1 tdo quiet on ir", 32'(ir_out), 32'h0);
        scan_dr(4, 32'hC, 1'b1, d);
        chk("R1 tdo quiet on dr", d, 32'h0);
        en = 1'b1;
        scan_dr(4, 32'hC, 1'b1, d);
        chk("R1 ignored while disabled", d, 32'h3);

        // release after miss-disable write
        pulse_ack();
        scan_ir(8'h12, ir_out);
        chk("R5 debug state cleared", 32'(ir_out), 32'h1);
        scan_dr(4, 32'h0, 1'b0, d);
        chk("R4 miss-disable bits", d, 32'hC);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule